// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running 64-bit time-of-day value, counted in whole nanoseconds, for a precision time protocol clock. Each enabled tick adds a 64-bit increment in 32.32 fixed point. The upper half is integer nanoseconds and the lower half is a binary fraction. A 32-bit fractional accumulator carries into the nanosecond count, so a tick period that is not a whole number of nanoseconds still averages out exactly over time.

Software reaches the block over a simple 32-bit register bus. Multi-word accesses are atomic:
- Reading the low time word freezes the whole value, and the following high-word read returns the frozen upper half.
- A time or increment write is held in a staging register and only takes effect when the high word arrives.

A two-bit link-speed input selects a multiplier for a base increment of 1.6 ns, written 0x1_99999999 in 32.32 fixed point. Software can also overwrite the increment directly to trim the frequency.

Top module: `ptp_tod_timer`

## Requirements
- R1: After reset the time reads 0, the increment reads 0x00000001_99999999, the enable bit reads 0, and the time does not advance.
- R2: On a cycle with tick high, the enable bit set and no committed time write, the time grows by the integer half of the increment plus the carry out of the fractional accumulator. The fractional accumulator grows by the fractional half, modulo 2^32.
- R3: A write to address 0 (time low) only stages data and leaves the time unchanged. A write to address 1 (time high) loads the time with {written data, staged low word} on the next clock edge and clears the fractional accumulator.
- R4: A read of address 0 returns the low time word and captures the high word of the same instant. A later read of address 1 returns that captured word, not the live high word.
- R5: A write to address 2 (increment low) only stages data and leaves the active increment unchanged. A write to address 3 (increment high) makes the increment {written data, staged low word}.
- R6: Address 4 bit 0 is the enable bit. While it is clear, ticks leave the time unchanged.
- R7: One clock after the speed_sel input takes a new value, the increment is reloaded with the base increment times a multiplier. The codes map as: 0 gives 1 (fastest link or no link), 1 gives 2, 2 gives 20, and 3 gives 0, which stops the clock. A direct write to the increment high word in the same cycle wins over the reload.
- R8: When a time-high write and an enabled tick fall in the same cycle, the written value is loaded and the tick is dropped.
- R9: Reads return data one clock after the read request. Addresses 2 and 3 return the active increment halves, address 4 returns the enable bit in bit 0 and zeros elsewhere, and addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance strobe, one increment per cycle it is high |
| speed_sel | input | 2 | Link-speed code selecting the increment multiplier |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_ns | output | 64 | Current nanosecond time |

## Verification
The time is tried with the base increment from zero, where the carry pattern of the fraction shows whether the fractional accumulator exists at all. It is also tried with each speed multiplier, where the exact reloaded values show whether the product is right, and with software-written increments whose large fractions make a carry on most ticks. Reads of the low word followed by ticks and then the high word tell a snapshot apart from a live read. Staged-only writes, and a time-high write that coincides with a tick, tell a commit on the high word apart from one on either word, and show whether the write has priority. Long random mixes of all accesses run against a bench model of the counter.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TIME_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIME_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_INC_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_INC_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;

  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_MID  = 2'd1,
    SPD_SLOW = 2'd2,
    SPD_STOP = 2'd3
  } speed_e;

  function automatic logic [4:0] speed_mult(input logic [1:0] code);
    case (speed_e'(code))
      SPD_FAST: return 5'd1;
      SPD_MID:  return 5'd2;
      SPD_SLOW: return 5'd20;
      default:  return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/tod_speed_scale.sv
module tod_speed_scale #(
  parameter int unsigned INC_W = 64,
  parameter logic [INC_W-1:0] BASE_INC = 64'h0000_0001_9999_9999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       speed_sel,
  output logic [1:0]       speed_q,
  output logic             reload,
  output logic [INC_W-1:0] reload_val
);
  import tod_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) speed_q <= 2'd0;
    else     speed_q <= speed_sel;
  end

  assign reload     = (speed_sel != speed_q);
  assign reload_val = BASE_INC * INC_W'(speed_mult(speed_sel));
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned NS_W   = 64,
  parameter int unsigned INT_W  = 32,
  parameter int unsigned FRAC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [NS_W-1:0]         load_val,
  input  logic                    step,
  input  logic [INT_W+FRAC_W-1:0] inc,
  output logic [NS_W-1:0]         time_ns,
  output logic [FRAC_W-1:0]       frac
);
  logic [FRAC_W:0]   frac_sum;
  logic [NS_W-1:0]   ns_add;

  assign frac_sum = {1'b0, frac} + {1'b0, inc[FRAC_W-1:0]};
  assign ns_add   = NS_W'(inc[INT_W+FRAC_W-1:FRAC_W]) + NS_W'(frac_sum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_ns <= '0;
      frac    <= '0;
    end else if (load) begin
      time_ns <= load_val;
      frac    <= '0;
    end else if (step) begin
      time_ns <= time_ns + ns_add;
      frac    <= frac_sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tod_regs.sv
module tod_regs #(
  parameter int unsigned NS_W  = 64,
  parameter int unsigned INC_W = 64,
  parameter logic [INC_W-1:0] BASE_INC = 64'h0000_0001_9999_9999
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [NS_W-1:0]   time_ns,
  input  logic              reload,
  input  logic [INC_W-1:0]  reload_val,
  output logic [31:0]       bus_rdata,
  output logic              time_load,
  output logic [NS_W-1:0]   time_load_val,
  output logic [INC_W-1:0]  inc_q,
  output logic              en_q,
  output logic [31:0]       stage_lo,
  output logic [31:0]       snap_hi
);
  import tod_pkg::*;
  localparam int unsigned HI_W = NS_W - BUS_W;
  localparam int unsigned IHI_W = INC_W - BUS_W;

  logic [31:0] inc_stage;
  logic        wr_tlo, wr_thi, wr_ilo, wr_ihi, wr_ctl;

  assign wr_tlo = bus_wr && (bus_addr == A_TIME_LO);
  assign wr_thi = bus_wr && (bus_addr == A_TIME_HI);
  assign wr_ilo = bus_wr && (bus_addr == A_INC_LO);
  assign wr_ihi = bus_wr && (bus_addr == A_INC_HI);
  assign wr_ctl = bus_wr && (bus_addr == A_CTRL);

  assign time_load     = wr_thi;
  assign time_load_val = {bus_wdata[HI_W-1:0], stage_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo  <= '0;
      inc_stage <= '0;
      inc_q     <= BASE_INC;
      en_q      <= 1'b0;
    end else begin
      if (wr_tlo) stage_lo  <= bus_wdata;
      if (wr_ilo) inc_stage <= bus_wdata;
      if (wr_ctl) en_q      <= bus_wdata[0];
      if (wr_ihi)      inc_q <= {bus_wdata[IHI_W-1:0], inc_stage};
      else if (reload) inc_q <= reload_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      snap_hi   <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_TIME_LO: begin
          bus_rdata <= time_ns[BUS_W-1:0];
          snap_hi   <= time_ns[NS_W-1:BUS_W];
        end
        A_TIME_HI: bus_rdata <= snap_hi;
        A_INC_LO:  bus_rdata <= inc_q[BUS_W-1:0];
        A_INC_HI:  bus_rdata <= inc_q[INC_W-1:BUS_W];
        A_CTRL:    bus_rdata <= {31'b0, en_q};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ptp_tod_timer.sv
module ptp_tod_timer #(
  parameter int unsigned NS_W   = 64,
  parameter int unsigned INT_W  = 32,
  parameter int unsigned FRAC_W = 32,
  parameter logic [INT_W+FRAC_W-1:0] BASE_INC = 64'h0000_0001_9999_9999
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic [1:0]  speed_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [63:0] time_ns
);
  localparam int unsigned INC_W = INT_W + FRAC_W;

  logic [1:0]        speed_q;
  logic              reload;
  logic [INC_W-1:0]  reload_val;
  logic              time_load;
  logic [NS_W-1:0]   time_load_val;
  logic [INC_W-1:0]  inc_q;
  logic              en_q;
  logic [31:0]       stage_lo;
  logic [31:0]       snap_hi;
  logic [FRAC_W-1:0] frac;

  tod_speed_scale #(.INC_W(INC_W), .BASE_INC(BASE_INC)) u_speed (
    .clk(clk), .rst(rst), .speed_sel(speed_sel), .speed_q(speed_q),
    .reload(reload), .reload_val(reload_val)
  );

  tod_regs #(.NS_W(NS_W), .INC_W(INC_W), .BASE_INC(BASE_INC)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .time_ns(time_ns),
    .reload(reload), .reload_val(reload_val), .bus_rdata(bus_rdata),
    .time_load(time_load), .time_load_val(time_load_val), .inc_q(inc_q),
    .en_q(en_q), .stage_lo(stage_lo), .snap_hi(snap_hi)
  );

  tod_accum #(.NS_W(NS_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .load(time_load), .load_val(time_load_val),
    .step(en_q && tick), .inc(inc_q), .time_ns(time_ns), .frac(frac)
  );
endmodule

// File: rtl/tod_checker.sv
module tod_checker (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic [1:0]  speed_sel,
  input logic [1:0]  speed_q,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [63:0] time_ns,
  input logic [63:0] inc_q,
  input logic        en_q,
  input logic [31:0] stage_lo,
  input logic [31:0] snap_hi,
  input logic [31:0] frac
);
  logic thi_wr;
  assign thi_wr = bus_wr && (bus_addr == 3'd1);

  AST_TIME_COMMIT: assert property (@(posedge clk) disable iff (rst)
    thi_wr |=> (time_ns == {$past(bus_wdata), $past(stage_lo)}) && (frac == 32'd0)); // R3

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick && !thi_wr) |=>
      ((time_ns - $past(time_ns)) == {32'd0, $past(inc_q[63:32])}) ||
      ((time_ns - $past(time_ns)) == {32'd0, $past(inc_q[63:32])} + 64'd1)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !thi_wr) |=> $stable(time_ns)); // R6

  AST_LO_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd0) |=> snap_hi == $past(time_ns[63:32])); // R4

  AST_INC_STAGED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd2 && speed_sel == speed_q) |=> $stable(inc_q)); // R5
endmodule

bind ptp_tod_timer tod_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .speed_sel(speed_sel), .speed_q(speed_q),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .time_ns(time_ns), .inc_q(inc_q), .en_q(en_q), .stage_lo(stage_lo),
  .snap_hi(snap_hi), .frac(frac)
);

// File: tb/sim_ptp_tod_timer.sv
module sim_ptp_tod_timer;
  localparam logic [63:0] BASE = 64'h0000_0001_9999_9999;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  speed_sel = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [63:0] time_ns;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [63:0] m_time, m_inc;
  logic [31:0] m_frac, m_stage, m_istage, m_snap, m_rd;
  logic        m_en;
  logic [1:0]  m_prev;

  always #5 clk = ~clk;

  ptp_tod_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .speed_sel(speed_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_ns(time_ns)
  );

  function automatic logic [63:0] f_scaled(input logic [1:0] sp);
    case (sp)
      2'd0: return BASE;
      2'd1: return BASE * 64'd2;
      2'd2: return BASE * 64'd20;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_time = 0; m_inc = BASE; m_frac = 0; m_stage = 0; m_istage = 0;
    m_snap = 0; m_rd = 0; m_en = 0; m_prev = 0;
  endtask

  // One bus/tick cycle: drive at negedge, update model, check at next negedge.
  task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] d, input logic tk, input logic [1:0] sp,
                     input string tag);
    logic [32:0] fs;
    logic [63:0] n_time, n_inc;
    logic [31:0] n_frac;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick = tk; speed_sel = sp;
    n_time = m_time; n_frac = m_frac; n_inc = m_inc;
    if (w && a == 3'd1) begin
      n_time = {d, m_stage}; n_frac = 0;
    end else if (m_en && tk) begin
      fs = {1'b0, m_frac} + {1'b0, m_inc[31:0]};
      n_frac = fs[31:0];
      n_time = m_time + {32'd0, m_inc[63:32]} + {63'd0, fs[32]};
    end
    if (w && a == 3'd3) n_inc = {d, m_istage};
    else if (sp != m_prev) n_inc = f_scaled(sp);
    if (r) begin
      case (a)
        3'd0: begin m_rd = m_time[31:0]; m_snap = m_time[63:32]; end
        3'd1: m_rd = m_snap;
        3'd2: m_rd = m_inc[31:0];
        3'd3: m_rd = m_inc[63:32];
        3'd4: m_rd = {31'd0, m_en};
        default: m_rd = 0;
      endcase
    end
    if (w && a == 3'd0) m_stage = d;
    if (w && a == 3'd2) m_istage = d;
    if (w && a == 3'd4) m_en = d[0];
    m_prev = sp; m_time = n_time; m_frac = n_frac; m_inc = n_inc;
    @(posedge clk);
    @(negedge clk);
    check64({tag, " time"}, time_ns, m_time);
    if (r) check64({tag, " rdata"}, {32'd0, bus_rdata}, {32'd0, m_rd});
  endtask

  task automatic idle(input logic tk, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 0, tk, speed_sel, tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    cyc(0, 1, a, 0, 0, speed_sel, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1, 0, a, d, 0, speed_sel, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values, no advance while disabled
    check64("R1 reset time", time_ns, 64'd0);
    rd(3'd2, "R1 inc lo");
    rd(3'd3, "R1 inc hi");
    rd(3'd4, "R1 ctrl");
    idle(1, 4, "R1 no advance");
    // R9: unmapped addresses read zero
    rd(3'd5, "R9 unmapped"); rd(3'd7, "R9 unmapped");
    // R2: enabled ticks with fractional carry (5 ticks of 1.6 -> 7)
    wr(3'd4, 32'd1, "R6 enable");
    rd(3'd4, "R9 ctrl");
    idle(1, 5, "R2 base ticks");
    check64("R2 five ticks", time_ns, 64'd7);
    idle(1, 20, "R2 more ticks");
    // R4: snapshot on low read
    wr(3'd0, 32'hFFFF_FFF0, "R3 stage lo");
    check64("R3 lo only no change", time_ns, m_time);
    wr(3'd1, 32'h0000_0005, "R3 commit hi");
    check64("R3 committed", time_ns, 64'h0000_0005_FFFF_FFF0);
    rd(3'd0, "R4 read lo");
    idle(1, 12, "R4 roll hi");
    rd(3'd1, "R4 snapshot hi");
    check64("R4 live hi moved", {32'd0, time_ns[63:32]}, 64'd6);
    // R8: write beats tick in same cycle
    wr(3'd0, 32'h1234_5678, "R8 stage");
    cyc(1, 0, 3'd1, 32'hA, 1, speed_sel, "R8 write+tick");
    check64("R8 write wins", time_ns, 64'h0000_000A_1234_5678);
    // R5: increment staged until high word
    wr(3'd2, 32'hC000_0000, "R5 stage inc lo");
    rd(3'd2, "R5 inc lo unchanged");
    idle(1, 3, "R5 old inc ticks");
    wr(3'd3, 32'd3, "R5 commit inc hi");
    rd(3'd2, "R5 inc lo new");
    idle(1, 6, "R5 new inc ticks");
    // R7: speed multipliers
    for (int s = 1; s < 4; s++) begin
      cyc(0, 0, 3'd0, 0, 1, 2'(s), "R7 speed change");
      rd(3'd2, "R7 scaled lo");
      rd(3'd3, "R7 scaled hi");
      idle(1, 4, "R7 scaled ticks");
    end
    check64("R7 stop speed inc", m_inc, 64'd0);
    cyc(0, 0, 3'd0, 0, 1, 2'd0, "R7 back to fast");
    rd(3'd3, "R7 fast hi");
    // R7: direct write wins over reload
    wr(3'd2, 32'h1, "R7 stage");
    cyc(1, 0, 3'd3, 32'h7, 0, 2'd1, "R7 write beats reload");
    rd(3'd3, "R7 written hi kept");
    // R6: disabled ticks ignored
    wr(3'd4, 32'd0, "R6 disable");
    idle(1, 8, "R6 disabled ticks");
    rd(3'd0, "R6 time unchanged");
    wr(3'd4, 32'd1, "R6 re-enable");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [1:0] sp;
      op = int'($urandom_range(0, 9));
      sp = ($urandom_range(0, 49) == 0) ? 2'($urandom_range(0, 3)) : speed_sel;
      if (op < 3)
        cyc(1, 0, 3'($urandom_range(0, 4)), $urandom, 1'($urandom_range(0, 1)), sp, "R2 random wr");
      else if (op < 6)
        cyc(0, 1, 3'($urandom_range(0, 7)), 0, 1'($urandom_range(0, 1)), sp, "R9 random rd");
      else
        cyc(0, 0, 3'd0, 0, 1'($urandom_range(0, 1)), sp, "R2 random tick");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule